// File: doc/BRIEF.md
# Fixed-Direction Port with Open-Drain Bits

This block is a six-bit register-mapped I/O port with no direction register. Every bit has a fixed role. Bits 0 and 1 are inputs only, and the level on bit 1 also goes straight to a timer as its external clock. Bits 2 and 3 are open-drain outputs backed by a two-bit data latch. Bits 4 and 5 belong to a serial peripheral, which sets both their drive value and their output enable.

The CPU side has an 8-bit write bus with a write strobe, and an 8-bit read bus with a read strobe. A write changes only the open-drain latch. A read captures the levels on the pins, not the latch. Because of this, a read-modify-write can change an open-drain bit. If a pin is held low from outside while its latch holds '1', the value read back and then written is '0', and the port starts driving that pin low.

The pin side gives each bit a pad input, a pad output value and an output enable. The pad, the pull-ups, the serial peripheral and the timer are outside this block.

Top module: `fixed_port`

## Requirements
- R1: After reset both open-drain latch bits are '1', so pad_oe[3:2] is 00, and rd_data is 0x00.
- R2: A write strobe loads wr_data[3:2] into the open-drain latch. For k = 2 and 3, from the next cycle pad_oe[k] equals the inverse of the latched bit and pad_out[k] is 0. A latched '0' drives the pin low and a latched '1' releases it.
- R3: A write has no effect on bits 0, 1, 4 and 5. pad_oe[1:0] and pad_out[1:0] are always 00, and bits 4 and 5 follow only the serial-peripheral inputs.
- R4: A read strobe captures pad_in into rd_data[5:0], visible the cycle after the strobe. With no strobe, rd_data holds its value.
- R5: rd_data[7:6] always reads 00.
- R6: tmr_clk equals pad_in[1] combinationally.
- R7: When sp_en is 1, pad_oe[5:4] equals sp_oe and pad_out[5:4] equals sp_out.
- R8: When sp_en is 0, pad_oe[5:4] and pad_out[5:4] are both 00, so bits 4 and 5 act as inputs.
- R9: sp_in equals pad_in[5:4] combinationally.
- R10: A read followed by a write of the value read turns on the drive of an open-drain bit whose latch held '1' while its pin was low from outside.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data; only bits 3:2 are used |
| rd_en | input | 1 | CPU read strobe |
| rd_data | output | 8 | Captured pin levels; bits 7:6 read zero |
| pad_in | input | 6 | Pin levels from the pads |
| pad_out | output | 6 | Drive value for each pad |
| pad_oe | output | 6 | Output enable for each pad |
| sp_en | input | 1 | Serial peripheral enabled |
| sp_out | input | 2 | Serial peripheral drive value for bits 5:4 |
| sp_oe | input | 2 | Serial peripheral output enable for bits 5:4 |
| sp_in | output | 2 | Pin levels of bits 5:4, sent to the serial peripheral |
| tmr_clk | output | 1 | Pin level of bit 1, sent to the timer |

## Verification
The assertions assume that wr_data carries no unknown bits whenever the write strobe is high. They also assume that the strobes and pad inputs are stable around each rising edge. The bench changes every input only on the falling clock edge and always drives fully defined values, including while the strobes are low. The read-modify-write case is produced by holding an open-drain pad low from outside while its latch is released, then writing the captured value back.

// File: rtl/port_pkg.sv
package port_pkg;
  localparam int PORT_W  = 6;
  localparam int BUS_W   = 8;
  localparam int OD_LO   = 2;
  localparam int OD_N    = 2;
  localparam int SP_LO   = 4;
  localparam int SP_N    = 2;
  localparam int TMR_BIT = 1;

  // Drive enable of an open-drain bit: enabled only when the latch holds zero.
  function automatic logic od_enable(input logic latch_bit);
    return ~latch_bit;
  endfunction

  // Put the pin levels on the low bits of the read bus and zero the rest.
  function automatic logic [BUS_W-1:0] pack_read(input logic [PORT_W-1:0] pins);
    logic [BUS_W-1:0] v;
    v = '0;
    v[PORT_W-1:0] = pins;
    return v;
  endfunction
endpackage

// File: rtl/opendrain_latch.sv
module opendrain_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_fire,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] od_oe,
  output logic [N-1:0] od_out
);
  import port_pkg::*;

  logic [N-1:0] latch_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       latch_q[i] <= 1'b1;
      else if (wr_fire) latch_q[i] <= wr_bits[i];
    end
    assign od_oe[i]  = od_enable(latch_q[i]);
    assign od_out[i] = 1'b0;
  end

  // R2: an enabled open-drain bit only ever drives low
  p_od_low_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (od_out & od_oe) == '0);

  // R3: with no write the drive enables do not change
  p_od_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(od_oe));
endmodule

// File: rtl/serial_takeover.sv
module serial_takeover #(
  parameter int N = 2
) (
  input  logic         sp_en,
  input  logic [N-1:0] sp_out,
  input  logic [N-1:0] sp_oe,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe
);
  always_comb begin
    pin_out = '0;
    pin_oe  = '0;
    if (sp_en) begin
      pin_out = sp_out;
      pin_oe  = sp_oe;
    end
  end
endmodule

// File: rtl/pin_readback.sv
module pin_readback #(
  parameter int PW = 6,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic [PW-1:0] pins,
  output logic [BW-1:0] rd_data
);
  import port_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (rd_fire) rd_data <= pack_read(pins);
  end

  // R4: the captured value is the pin level seen at the strobe edge
  p_read_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_data[PW-1:0] == $past(pins));

  // R4: with no strobe the read value holds
  p_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_data));

  // R5: bus bits above the port width read zero
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BW-1:PW] == '0);
endmodule

// File: rtl/fixed_port.sv
module fixed_port
  import port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              rd_en,
  output logic [BUS_W-1:0]  rd_data,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  input  logic              sp_en,
  input  logic [SP_N-1:0]   sp_out,
  input  logic [SP_N-1:0]   sp_oe,
  output logic [SP_N-1:0]   sp_in,
  output logic              tmr_clk
);
  // Named strobes, used by the assertions
  logic wr_fire;
  logic rd_fire;
  assign wr_fire = wr_en;
  assign rd_fire = rd_en;

  logic [OD_N-1:0] od_oe_w, od_out_w;
  logic [SP_N-1:0] sp_pin_out_w, sp_pin_oe_w;

  opendrain_latch #(.N(OD_N)) u_od (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_bits (wr_data[OD_LO +: OD_N]),
    .od_oe   (od_oe_w),
    .od_out  (od_out_w)
  );

  serial_takeover #(.N(SP_N)) u_sp (
    .sp_en   (sp_en),
    .sp_out  (sp_out),
    .sp_oe   (sp_oe),
    .pin_out (sp_pin_out_w),
    .pin_oe  (sp_pin_oe_w)
  );

  pin_readback #(.PW(PORT_W), .BW(BUS_W)) u_rb (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_fire (rd_fire),
    .pins    (pad_in),
    .rd_data (rd_data)
  );

  // Put together the per-pin outputs; the input-only bits never drive
  always_comb begin
    pad_out = '0;
    pad_oe  = '0;
    pad_out[OD_LO +: OD_N] = od_out_w;
    pad_oe [OD_LO +: OD_N] = od_oe_w;
    pad_out[SP_LO +: SP_N] = sp_pin_out_w;
    pad_oe [SP_LO +: SP_N] = sp_pin_oe_w;
  end

  assign sp_in   = pad_in[SP_LO +: SP_N];
  assign tmr_clk = pad_in[TMR_BIT];

  // R2: a write sets the drive enables to the inverse of the written bits
  p_write_od_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> pad_oe[OD_LO +: OD_N] == ~$past(wr_data[OD_LO +: OD_N]));

  // R3: write data must be defined whenever the strobe is high
  p_wr_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !$isunknown(wr_data));

  // R3: the input-only bits never drive
  p_inputs_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[1:0] == 2'b00);

  // R7: the serial peripheral owns bits 5:4 while it is enabled
  p_sp_own_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sp_en |-> pad_oe[SP_LO +: SP_N] == sp_oe && pad_out[SP_LO +: SP_N] == sp_out);

  // R8: bits 5:4 are released while the serial peripheral is off
  p_sp_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_en |-> pad_oe[SP_LO +: SP_N] == '0);
endmodule

// File: tb/fixed_port_tb.sv
module fixed_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [5:0] pad_in = 6'h00;
  logic [5:0] pad_out, pad_oe;
  logic       sp_en = 1'b0;
  logic [1:0] sp_out = 2'b00, sp_oe = 2'b00;
  logic [1:0] sp_in;
  logic       tmr_clk;

  always #(CLK_PERIOD/2) clk = ~clk;

  fixed_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .sp_en(sp_en), .sp_out(sp_out), .sp_oe(sp_oe),
    .sp_in(sp_in), .tmr_clk(tmr_clk)
  );

  // Observed bundle: {rd_data, pad_out, pad_oe, sp_in, tmr_clk} = 23 bits
  typedef struct {
    string       req;
    logic [22:0] exp;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // Reference model state
  logic [1:0] m_od;
  logic [7:0] m_rd;

  function automatic logic [22:0] model_obs();
    logic [5:0] o, e;
    o = 6'b0;
    e = 6'b0;
    e[3:2] = ~m_od;
    if (sp_en) begin
      o[5:4] = sp_out;
      e[5:4] = sp_oe;
    end
    return {m_rd, o, e, pad_in[5:4], pad_in[1]};
  endfunction

  task automatic push(input string req);
    item_t it;
    it.req = req;
    it.exp = model_obs();
    q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  // One bus cycle: drive at the falling edge, update the model at the rising edge
  task automatic cycle(input logic w, input logic [7:0] d, input logic r, input string req);
    @(negedge clk);
    wr_en = w;
    wr_data = d;
    rd_en = r;
    @(posedge clk);
    if (r) m_rd = {2'b00, pad_in};
    if (w) m_od = d[3:2];
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    push(req);
  endtask

  // Monitor: compares the design against every queued item
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [22:0] act;
        it = q.pop_front();
        act = {rd_data, pad_out, pad_oe, sp_in, tmr_clk};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin
    m_od = 2'b11;
    m_rd = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push("R1");                                   // reset state: latch released, read zero

    cycle(1'b1, 8'h00, 1'b0, "R2");              // both open-drain bits drive low
    cycle(1'b1, 8'hF7, 1'b0, "R3");              // bit 3 drives low, bit 2 released; other bits stay quiet
    cycle(1'b1, 8'h0C, 1'b0, "R2");              // both open-drain bits released

    pad_in = 6'b101010;
    cycle(1'b0, 8'h00, 1'b1, "R4");              // read captures pins
    push("R6");                                   // timer clock follows bit 1
    push("R9");                                   // serial inputs follow bits 5:4
    @(negedge clk);
    pad_in = 6'b010101;
    @(negedge clk);
    push("R4");                                   // with no strobe the read value holds
    push("R6");                                   // bit 1 now low
    pad_in = 6'b111111;
    cycle(1'b0, 8'h00, 1'b1, "R5");              // bits 7:6 stay zero

    @(negedge clk);
    sp_en = 1'b1;
    sp_oe = 2'b01;
    sp_out = 2'b11;
    #1;
    push("R7");                                   // peripheral owns bits 5:4
    cycle(1'b1, 8'hFF, 1'b0, "R3");              // write leaves bits 5:4 to the peripheral
    sp_oe = 2'b10;
    sp_out = 2'b01;
    #1;
    push("R7");
    sp_en = 1'b0;
    #1;
    push("R8");                                   // peripheral off: bits 5:4 released

    // Read-modify-write: bit 2 released but held low outside
    cycle(1'b1, 8'h0C, 1'b0, "R10");
    pad_in = 6'b111011;
    cycle(1'b0, 8'h00, 1'b1, "R10");
    cycle(1'b1, rd_data, 1'b0, "R10");           // bit 2 now drives low, bit 3 stays released
    // Read and write in the same cycle
    pad_in = 6'b000000;
    cycle(1'b1, 8'h00, 1'b1, "R4");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule